// File: doc/BRIEF.md
# Mailbox-Command I2C Master

This block is an I2C bus master controlled through six 16-bit register words. Software loads up to two payload bytes into a write-payload word, then writes a command word that launches exactly one bus transaction. The command names a 7-bit target, the direction, a one- or two-byte length, an address-only probe option and a keep-bus option. Bytes read from the target come back in a read-payload word. Completion and failure are reported as sticky event flags that software clears by writing ones. The flags can also be routed to an interrupt line through an enable mask.

A single command moves at most two bytes. Longer transfers are chained: a command with the keep-bus option ends without a stop and leaves SCL low. The next command then opens with a repeated start instead of a fresh start. If the target refuses an acknowledge, the engine always finishes with a stop and releases the bus, whatever the keep-bus option says. SCL is timed by a quarter-bit divider set by the parameter `QTR_CYCLES`. Clock stretching, arbitration between masters and 10-bit addressing are not handled.

Top module: `mbx_i2c_master`

## Requirements
- R1: Word index 0 is event status, 1 is event enable, 2 is write payload, 3 is command, 4 is read payload, and 5 always reads zero. After reset every word reads zero, irq is 0, and SCL and SDA are both released (1).
- R2: A write to index 3 starts a transaction only when bits 15:14 equal 2 and no transaction is in progress. Any other command write causes no bus activity and no event.
- R3: Command bits 7:1 give the target address and bit 10 = 1 selects a write. The address byte carries R/W = 0 for a write and 1 for a read. Bit 11 = 1 selects two payload bytes, and 0 selects one. Payload is sent from the write-payload word low byte first, MSB first within each byte.
- R4: A read places the first received byte in bits 7:0 and the second in bits 15:8 of index 4, clearing the word when the read starts. The master ACKs every byte except the last, which it NACKs.
- R5: A successful write command sets status bit 14 and a successful read command sets status bit 15. Exactly one event is raised per command, and the engine is idle on the cycle after it.
- R6: A missing acknowledge to the address or to a written byte sets status bit 13 instead. In that case a stop is always issued, even when command bit 13 is set.
- R7: Writing a 1 to status bit 13, 14 or 15 clears that bit, and writing 0 leaves it unchanged. An event arriving in the same cycle wins over the clear.
- R8: Command bit 12 = 1 makes a probe: only the address phase runs, and no payload byte is moved.
- R9: Command bit 13 = 1 ends a successful transfer without a stop and holds SCL low. The next accepted command begins with a repeated start.
- R10: irq is 1 exactly when some status bit among 15:13 is set and the same bit of the enable word (index 1, bits 15:13) is set.
- R11: Each bit lasts 4*QTR_CYCLES clocks. SDA changes while SCL is high only for a start, a repeated start or a stop, and the bus stays released while no transaction is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Masked event interrupt |
| scl_o | output | 1 | SCL drive, 1 = released, 0 = pull low |
| sda_o | output | 1 | SDA drive, 1 = released, 0 = pull low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
A behavioural target on the bus answers at one address. It records written bytes and the master's acknowledges, and serves read bytes from a queue. Two-byte writes and reads show the byte order and the ACK-then-NACK pattern, and one-byte reads show that the high half is cleared. A wrong address, a refused data byte and a probe separate the error path from the done paths and from payload movement. A held write followed by a read shows a start counted without a stop. Commands with a bad tag, or sent while busy, must leave the bus and the status untouched.

// File: rtl/mbx_i2c_pkg.sv
package mbx_i2c_pkg;

    localparam int REG_STAT = 0;
    localparam int REG_IEN  = 1;
    localparam int REG_WEXT = 2;
    localparam int REG_CMD  = 3;
    localparam int REG_REXT = 4;

    localparam int EV_LO     = 13;
    localparam int CMD_WR    = 10;
    localparam int CMD_TWO   = 11;
    localparam int CMD_PROBE = 12;
    localparam int CMD_HOLD  = 13;
    localparam logic [1:0] CMD_TAG = 2'b10;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_ADDR, PH_AACK, PH_DATA, PH_DACK, PH_STOP
    } phase_e;

    typedef struct packed {
        logic [6:0] addr;
        logic       wr;
        logic       two;
        logic       probe;
        logic       hold;
    } cmd_t;

endpackage

// File: rtl/mbx_i2c_qtick.sv
module mbx_i2c_qtick #(
    parameter int QTR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = '0;
        if (run && !tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mbx_i2c_engine.sv
module mbx_i2c_engine
    import mbx_i2c_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        start,
    input  cmd_t        cmd,
    input  logic [15:0] wdata,
    input  logic        sda_i,
    output logic        busy,
    output phase_e      phase,
    output logic        scl_o,
    output logic        sda_o,
    output logic        done_wr,
    output logic        done_rd,
    output logic        err,
    output logic [15:0] rdata
);
    typedef struct packed {
        phase_e      ph;
        logic [1:0]  qtr;
        logic [2:0]  bitn;
        logic        idx;
        logic [7:0]  sh;
        logic [15:0] rd;
        logic        held;
        logic        rs;
        logic        nack;
        logic        fail;
        cmd_t        c;
        logic [15:0] wd;
    } eng_t;

    eng_t q, d;
    logic last_byte, done;

    assign last_byte = !(q.c.two && !q.idx);

    always_comb begin
        d    = q;
        done = 1'b0;
        err  = 1'b0;
        if (q.ph == PH_IDLE) begin
            if (start) begin
                d.c    = cmd;
                d.wd   = wdata;
                d.rd   = cmd.wr ? q.rd : 16'h0;
                d.rs   = q.held;
                d.ph   = PH_START;
                d.qtr  = 2'd0;
                d.idx  = 1'b0;
                d.fail = 1'b0;
            end
        end else if (tick) begin
            d.qtr = q.qtr + 2'd1;
            if (q.qtr == 2'd2) begin
                if (q.ph == PH_AACK || (q.ph == PH_DACK && q.c.wr)) d.nack = sda_i;
                if (q.ph == PH_DATA && !q.c.wr) d.sh = {q.sh[6:0], sda_i};
            end
            if (q.qtr == 2'd3) begin
                unique case (q.ph)
                    PH_START: begin
                        d.ph   = PH_ADDR;
                        d.bitn = 3'd0;
                        d.sh   = {q.c.addr, !q.c.wr};
                        d.held = 1'b0;
                    end
                    PH_ADDR: begin
                        d.sh   = q.sh << 1;
                        d.bitn = q.bitn + 3'd1;
                        if (q.bitn == 3'd7) d.ph = PH_AACK;
                    end
                    PH_AACK: begin
                        if (q.nack) begin
                            d.fail = 1'b1;
                            d.ph   = PH_STOP;
                        end else if (q.c.probe) begin
                            d.ph   = q.c.hold ? PH_IDLE : PH_STOP;
                            d.held = q.c.hold;
                            done   = q.c.hold;
                        end else begin
                            d.ph   = PH_DATA;
                            d.bitn = 3'd0;
                            d.sh   = q.c.wr ? q.wd[7:0] : 8'h00;
                        end
                    end
                    PH_DATA: begin
                        if (q.c.wr) d.sh = q.sh << 1;
                        d.bitn = q.bitn + 3'd1;
                        if (q.bitn == 3'd7) d.ph = PH_DACK;
                    end
                    PH_DACK: begin
                        if (q.c.wr && q.nack) begin
                            d.fail = 1'b1;
                            d.ph   = PH_STOP;
                        end else begin
                            if (!q.c.wr) begin
                                if (q.idx) d.rd[15:8] = q.sh;
                                else       d.rd[7:0]  = q.sh;
                            end
                            if (!last_byte) begin
                                d.idx  = 1'b1;
                                d.ph   = PH_DATA;
                                d.bitn = 3'd0;
                                d.sh   = q.c.wr ? q.wd[15:8] : 8'h00;
                            end else begin
                                d.ph   = q.c.hold ? PH_IDLE : PH_STOP;
                                d.held = q.c.hold;
                                done   = q.c.hold;
                            end
                        end
                    end
                    PH_STOP: begin
                        d.ph   = PH_IDLE;
                        d.held = 1'b0;
                        done   = !q.fail;
                        err    = q.fail;
                    end
                    default: d.ph = PH_IDLE;
                endcase
            end
        end
        done_wr = done && q.c.wr;
        done_rd = done && !q.c.wr;
    end

    always_comb begin
        scl_o = (q.qtr == 2'd1) || (q.qtr == 2'd2);
        sda_o = 1'b1;
        unique case (q.ph)
            PH_IDLE:  scl_o = !q.held;
            PH_START: begin
                scl_o = (q.qtr == 2'd0) ? !q.rs : (q.qtr != 2'd3);
                sda_o = (q.qtr < 2'd2);
            end
            PH_STOP: begin
                scl_o = (q.qtr != 2'd0);
                sda_o = (q.qtr >= 2'd2);
            end
            PH_ADDR:  sda_o = q.sh[7];
            PH_AACK:  sda_o = 1'b1;
            PH_DATA:  sda_o = q.c.wr ? q.sh[7] : 1'b1;
            PH_DACK:  sda_o = q.c.wr ? 1'b1 : last_byte;
            default:  sda_o = 1'b1;
        endcase
    end

    assign busy  = (q.ph != PH_IDLE);
    assign phase = q.ph;
    assign rdata = q.rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mbx_i2c_regs.sv
module mbx_i2c_regs
    import mbx_i2c_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    input  logic        busy,
    input  logic [2:0]  ev,
    input  logic [15:0] rd_ext,
    output logic [15:0] rdata,
    output logic        irq,
    output logic        start,
    output cmd_t        cmd,
    output logic [15:0] wext,
    output logic [2:0]  stat
);
    typedef struct packed {
        logic [2:0]  stat;
        logic [2:0]  ien;
        logic [15:0] wext;
        logic [15:0] cmdw;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d     = q;
        start = 1'b0;
        cmd   = '{addr: wdata[7:1], wr: wdata[CMD_WR], two: wdata[CMD_TWO],
                  probe: wdata[CMD_PROBE], hold: wdata[CMD_HOLD]};
        if (we) begin
            unique case (int'(addr))
                REG_STAT: d.stat = q.stat & ~wdata[EV_LO +: 3];
                REG_IEN:  d.ien  = wdata[EV_LO +: 3];
                REG_WEXT: d.wext = wdata;
                REG_CMD: begin
                    if (wdata[15:14] == CMD_TAG && !busy) begin
                        start  = 1'b1;
                        d.cmdw = wdata;
                    end
                end
                default: ;
            endcase
        end
        d.stat = d.stat | ev;
    end

    always_comb begin
        unique case (int'(addr))
            REG_STAT: rdata = {q.stat, 13'h0};
            REG_IEN:  rdata = {q.ien, 13'h0};
            REG_WEXT: rdata = q.wext;
            REG_CMD:  rdata = q.cmdw;
            REG_REXT: rdata = rd_ext;
            default:  rdata = 16'h0;
        endcase
    end

    assign irq  = |(q.stat & q.ien);
    assign wext = q.wext;
    assign stat = q.stat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mbx_i2c_master.sv
module mbx_i2c_master
    import mbx_i2c_pkg::*;
#(
    parameter int QTR_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        scl_o,
    output logic        sda_o,
    input  logic        sda_i
);
    logic        eng_busy, eng_tick, eng_start;
    logic        done_wr, done_rd, eng_err;
    logic [2:0]  ev_bits, stat_bits;
    logic [15:0] eng_rdata, wext;
    cmd_t        cmd;
    phase_e      eng_phase;

    assign ev_bits = {done_rd, done_wr, eng_err};

    mbx_i2c_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .busy(eng_busy), .ev(ev_bits), .rd_ext(eng_rdata), .rdata(reg_rdata),
        .irq(irq), .start(eng_start), .cmd(cmd), .wext(wext), .stat(stat_bits)
    );

    mbx_i2c_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .tick(eng_tick)
    );

    mbx_i2c_engine u_eng (
        .clk(clk), .rst_n(rst_n), .tick(eng_tick), .start(eng_start), .cmd(cmd),
        .wdata(wext), .sda_i(sda_i), .busy(eng_busy), .phase(eng_phase),
        .scl_o(scl_o), .sda_o(sda_o), .done_wr(done_wr), .done_rd(done_rd),
        .err(eng_err), .rdata(eng_rdata)
    );
endmodule

// File: rtl/mbx_i2c_checker.sv
module mbx_i2c_checker
    import mbx_i2c_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic [2:0]  stat,
    input logic [2:0]  ev,
    input logic        busy,
    input phase_e      phase,
    input logic        scl_o,
    input logic        sda_o
);
    a_r11_sda_moves_with_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |-> (phase == PH_START || phase == PH_STOP));

    a_r7_w1c_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && reg_wdata[13] && !ev[0]) |=> !stat[0]);

    a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev));

    a_r5_idle_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> !busy);

    a_r6_error_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ev[0] |=> (scl_o && sda_o));

    a_r2_bad_tag_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd3 && reg_wdata[15:14] != 2'b10 && !busy) |=> !busy);
endmodule

bind mbx_i2c_master mbx_i2c_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .stat(stat_bits), .ev(ev_bits), .busy(eng_busy),
    .phase(eng_phase), .scl_o(scl_o), .sda_o(sda_o)
);

// File: tb/sim_mbx_i2c_master.sv
module sim_mbx_i2c_master;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = 4;
    localparam logic [6:0] SLV = 7'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq, scl_o, sda_o, sda_i;
    logic        slv_drv = 1'b1;

    int checks = 0, fails = 0, cyc = 0;
    bit quiet = 1'b0, ended = 1'b0;

    // behavioural target state
    logic [7:0] wq[$], rq[$];
    logic       ackq[$];
    int  starts = 0, stops = 0, rise_cnt = 0, t_rise0 = 0, t_rise1 = 0;
    logic prev_scl = 1'b1, prev_sda = 1'b1, sl_active = 1'b0, sl_rw = 1'b0;
    logic [7:0] sl_sh = 8'h0, cur_rd = 8'hFF;
    bit nack_addr = 1'b0, nack_data = 1'b0;

    assign sda_i = sda_o & slv_drv;

    mbx_i2c_master #(.QTR_CYCLES(QTR)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [6:0] a, input bit wr, input bit two,
                                       input bit probe, input bit hold);
        return 16'h8000 | (16'(hold) << 13) | (16'(probe) << 12) | (16'(two) << 11)
             | (16'(wr) << 10) | (16'(a) << 1);
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] v);
        @(posedge clk);
        reg_we <= 1'b1; reg_addr <= a; reg_wdata <= v;
        @(posedge clk);
        reg_we <= 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
        @(posedge clk);
        reg_addr <= a;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic run_cmd(input logic [15:0] c, output logic [15:0] st);
        quiet = 1'b0;
        wr_reg(3'd3, c);
        st = 16'h0;
        for (int i = 0; i < 5000; i++) begin
            rd_reg(3'd0, st);
            if ((st & 16'hE000) != 16'h0) break;
        end
        quiet = !(c[13] && !st[13]);
    endtask

    // per-clock reference: cycle count, idle bus and target protocol model
    always @(negedge clk) begin
        logic cs, cd;
        int b;
        cyc++;
        if (rst_n && quiet) begin
            checks++;
            if (!(scl_o && sda_o)) begin
                fails++;
                $display("FAIL R11 idle bus actual=%b%b expected=11", scl_o, sda_o);
            end
        end
        cs = scl_o;
        cd = sda_o & slv_drv;
        if (prev_scl && cs && prev_sda && !cd) begin
            starts++; rise_cnt = 0; sl_active = 1'b1; sl_sh = 8'h0; slv_drv = 1'b1;
        end else if (prev_scl && cs && !prev_sda && cd) begin
            stops++; sl_active = 1'b0; slv_drv = 1'b1;
        end else if (!prev_scl && cs) begin
            if (rise_cnt == 0) t_rise0 = cyc;
            if (rise_cnt == 1) t_rise1 = cyc;
            if (sl_active) begin
                if (rise_cnt < 8) sl_sh = {sl_sh[6:0], cd};
                else if (rise_cnt >= 9) begin
                    b = (rise_cnt - 9) % 9;
                    if (!sl_rw) begin
                        if (b < 8) sl_sh = {sl_sh[6:0], cd};
                        if (b == 7) wq.push_back(sl_sh);
                    end else if (b == 8) begin
                        ackq.push_back(cd);
                        if (cd) sl_active = 1'b0;
                    end
                end
            end
            rise_cnt++;
        end else if (prev_scl && !cs) begin
            slv_drv = 1'b1;
            if (sl_active) begin
                if (rise_cnt == 8) begin
                    if (sl_sh[7:1] == SLV && !nack_addr) begin
                        slv_drv = 1'b0; sl_rw = sl_sh[0];
                    end else sl_active = 1'b0;
                end else if (rise_cnt >= 9) begin
                    b = (rise_cnt - 9) % 9;
                    if (!sl_rw) begin
                        if (b == 8) slv_drv = nack_data;
                    end else if (b < 8) begin
                        if (b == 0) cur_rd = (rq.size() > 0) ? rq.pop_front() : 8'hFF;
                        slv_drv = cur_rd[7-b];
                    end
                end
            end
        end
        prev_scl = cs;
        prev_sda = sda_o & slv_drv;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, st;
        int s0, p0, n0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_reg(3'd0, v); chk("R1 status reset", v, 16'h0);
        rd_reg(3'd4, v); chk("R1 read payload reset", v, 16'h0);
        rd_reg(3'd5, v); chk("R1 index 5 zero", v, 16'h0);
        chk("R1 irq reset", irq, 1'b0);
        chk("R1 bus released", {scl_o, sda_o}, 2'b11);
        quiet = 1'b1;

        // R3 two-byte write, R5 transmit event, R11 bit period
        wr_reg(3'd2, 16'hBEA5);
        p0 = stops;
        run_cmd(mk(SLV, 1, 1, 0, 0), st);
        chk("R5 write done event", st, 16'h4000);
        chk("R3 byte count", wq.size(), 2);
        if (wq.size() == 2) begin
            chk("R3 low byte first", wq[0], 8'hA5);
            chk("R3 high byte second", wq[1], 8'hBE);
        end
        chk("R11 bit period", t_rise1 - t_rise0, 4 * QTR);
        chk("R3 stop issued", stops - p0, 1);

        // R7 write-one-to-clear
        wr_reg(3'd0, 16'h4000);
        rd_reg(3'd0, v); chk("R7 clear transmit event", v, 16'h0);

        // R4 two-byte read
        rq.push_back(8'h3C); rq.push_back(8'hD2); ackq.delete();
        run_cmd(mk(SLV, 0, 1, 0, 0), st);
        chk("R5 read done event", st, 16'h8000);
        rd_reg(3'd4, v); chk("R4 two-byte read order", v, 16'hD23C);
        chk("R4 master ack count", ackq.size(), 2);
        if (ackq.size() == 2) chk("R4 ack then nack", {ackq[0], ackq[1]}, 2'b01);
        wr_reg(3'd0, 16'hE000);

        // R4 one-byte read clears high half
        rq.push_back(8'h77);
        run_cmd(mk(SLV, 0, 0, 0, 0), st);
        chk("R5 one-byte read event", st, 16'h8000);
        rd_reg(3'd4, v); chk("R4 one-byte read", v, 16'h0077);
        wr_reg(3'd0, 16'hE000);

        // R6 address nack
        p0 = stops;
        run_cmd(mk(7'h51, 1, 0, 0, 0), st);
        chk("R6 address nack error", st, 16'h2000);
        chk("R6 stop after nack", stops - p0, 1);
        wr_reg(3'd0, 16'hC000);
        rd_reg(3'd0, v); chk("R7 zero bits leave error set", v, 16'h2000);
        wr_reg(3'd0, 16'h2000);
        rd_reg(3'd0, v); chk("R7 clear error", v, 16'h0);

        // R8 probe
        n0 = wq.size();
        run_cmd(mk(SLV, 1, 0, 1, 0), st);
        chk("R8 probe present", st, 16'h4000);
        chk("R8 probe moves no byte", wq.size(), n0);
        wr_reg(3'd0, 16'hE000);
        run_cmd(mk(7'h22, 1, 0, 1, 0), st);
        chk("R8 probe absent", st, 16'h2000);
        wr_reg(3'd0, 16'hE000);

        // R9 hold then repeated start
        s0 = starts; p0 = stops;
        wr_reg(3'd2, 16'h0011);
        run_cmd(mk(SLV, 1, 0, 0, 1), st);
        chk("R9 held write event", st, 16'h4000);
        chk("R9 scl held low", scl_o, 1'b0);
        chk("R9 no stop while held", stops - p0, 0);
        wr_reg(3'd0, 16'hE000);
        rq.push_back(8'h9A);
        run_cmd(mk(SLV, 0, 0, 0, 0), st);
        chk("R9 read after hold", st, 16'h8000);
        chk("R9 two starts one stop", {starts - s0, stops - p0}, {32'd2, 32'd1});
        rd_reg(3'd4, v); chk("R9 data after repeated start", v, 16'h009A);
        if (wq.size() > 0) chk("R9 held byte written", wq[wq.size()-1], 8'h11);
        wr_reg(3'd0, 16'hE000);

        // R6 data nack with hold still stops
        nack_data = 1'b1; p0 = stops;
        run_cmd(mk(SLV, 1, 0, 0, 1), st);
        chk("R6 data nack error", st, 16'h2000);
        chk("R6 bus released despite hold", {scl_o, sda_o}, 2'b11);
        chk("R6 stop despite hold", stops - p0, 1);
        nack_data = 1'b0;
        wr_reg(3'd0, 16'hE000);

        // R2 bad tag ignored
        s0 = starts;
        wr_reg(3'd3, 16'h4000 | 16'h0400 | (16'(SLV) << 1));
        repeat (200) @(posedge clk);
        rd_reg(3'd0, v); chk("R2 bad tag no event", v, 16'h0);
        chk("R2 bad tag no start", starts - s0, 0);

        // R2 command while busy ignored
        s0 = starts; n0 = wq.size();
        wr_reg(3'd2, 16'h0055);
        quiet = 1'b0;
        wr_reg(3'd3, mk(SLV, 1, 0, 0, 0));
        repeat (10) @(posedge clk);
        wr_reg(3'd3, mk(SLV, 1, 1, 0, 0));
        st = 16'h0;
        for (int i = 0; i < 5000; i++) begin
            rd_reg(3'd0, st);
            if ((st & 16'hE000) != 16'h0) break;
        end
        repeat (400) @(posedge clk);
        quiet = 1'b1;
        chk("R2 busy first done", st, 16'h4000);
        chk("R2 busy one start", starts - s0, 1);
        chk("R2 busy one byte", wq.size() - n0, 1);

        // R10 interrupt masking
        rd_reg(3'd0, v);
        wr_reg(3'd1, 16'h4000);
        @(negedge clk); chk("R10 irq enabled", irq, 1'b1);
        wr_reg(3'd1, 16'h8000);
        @(negedge clk); chk("R10 irq masked", irq, 1'b0);
        rd_reg(3'd1, v); chk("R10 enable readback", v, 16'h8000);
        wr_reg(3'd0, 16'hE000);
        wr_reg(3'd1, 16'hE000);
        @(negedge clk); chk("R10 irq after clear", irq, 1'b0);

        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule